// File: doc/BRIEF.md
# System Control Register Block

This block is a bank of 32-bit control and identification words that sits on a simple word-wide register bus. After power-on reset it holds fixed values for the chip identity, revision, configuration, clock, reset and pin-mux words. Every other word in the window starts at zero. Software can read and overwrite every word in the window, the identity words included. The stored values do not drive any other logic.

One word has a side effect. The reset-control word sits at byte offset 0x34, which is word index 13. A write to it whose bit 0 is 1 produces a whole-system reset request. Accesses beyond the last word are dropped without any error indication.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word 0x00 reads 0x3637544D, word 0x04 reads 0x20203832, word 0x0C reads 0x00010102 and word 0x08 reads 0x01010000.
- R2: After reset, these words read as follows:
  - 0x14 reads 0x02605500 and 0x10 reads 0x00144144.
  - 0x30 reads 0xF69F7F00 and 0x2C reads 0x00201000.
  - 0x38 reads 0xC0030000 and 0x34 reads 0x04000400.
  - 0x3C reads 0x001F001F.
  - 0x64 reads 0x05550555 and 0x60 reads 0x54050404.
- R3: After reset, every other word in the window reads 0. The window holds 65 words at byte offsets 0x000 to 0x100, and the word index is the byte offset divided by 4.
- R4: Read timing:
  - A read request (valid high, write low) places the addressed word on `bus_rdata` in the cycle after the request.
  - `bus_rdata` holds its value in cycles that follow no read request.
  - `bus_rdata` is 0 during reset.
- R5: Every in-range word, the identity words included, is plain 32-bit storage. A read returns the last full word written to it.
- R6: A read whose word index is 65 or more returns 0.
- R7: A write whose word index is 65 or more changes no word. It also never raises the reset request, even when its index differs from index 13 only in the upper bits.
- R8: A write to word index 13 stores the value. If bit 0 of the value is 1, `sys_reset_req` is high for exactly the one cycle after the write.
- R9: `sys_reset_req` stays low in these cases:
  - a write to index 13 with bit 0 at 0;
  - a write with bit 0 at 1 to any other word;
  - any read;
  - idle cycles, even while the stored bit 0 of word 13 is 1.
- R10: Address bits 1:0 are ignored, so every access acts on the word that holds the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle whole-system reset request |

## Verification
A write of a value with bit 0 set to the reset-control word does two things in the same cycle: it updates storage and it raises the reset request. The bench issues such writes and checks the following:
- the pulse is high in the cycle after the write and low in the cycle after that;
- a read in the very next cycle returns the full written word.

The bench also checks that the stored bit 0 of 1 causes no further pulse during idle cycles. It repeats the same write through an address whose low bits are not zero, and through an out-of-range address that shares the low index bits. In the second case it expects no pulse and an unchanged word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int WORD_W = 32;

  // Power-on value of each word, selected by word index.
  function automatic logic [WORD_W-1:0] init_word(input int unsigned idx);
    case (idx)
      0:       return 32'h3637544D;
      1:       return 32'h20203832;
      2:       return 32'h01010000;
      3:       return 32'h00010102;
      4:       return 32'h00144144;
      5:       return 32'h02605500;
      11:      return 32'h00201000;
      12:      return 32'hF69F7F00;
      13:      return 32'h04000400;
      14:      return 32'hC0030000;
      15:      return 32'h001F001F;
      24:      return 32'h54050404;
      25:      return 32'h05550555;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec #(
  parameter int IDX_W      = 10,
  parameter int NUM_WORDS  = 65,
  parameter int RSTCTL_IDX = 13
) (
  input  logic [IDX_W-1:0] word_idx,
  output logic             in_range,
  output logic             is_rstctl
);
  assign in_range  = (word_idx < IDX_W'(NUM_WORDS));
  assign is_rstctl = (word_idx == IDX_W'(RSTCTL_IDX));
endmodule

// File: rtl/sysctl_word_file.sv
module sysctl_word_file
  import sysctl_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int NUM_WORDS = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  // Each word carries its own power-on value, so storage is flops.
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= init_word(g);
      else if (wr_en && idx == IDX_W'(g))
        words[g] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (idx == IDX_W'(i)) rd_word = words[i];
  end
endmodule

// File: rtl/sysctl_rst_pulse.sv
module sysctl_rst_pulse #(
  parameter int TRIG_BIT = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_write,
  input  logic [31:0] ctl_data,
  output logic        req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= ctl_write && ctl_data[TRIG_BIT];
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_WORDS  = 65,
  parameter int RSTCTL_IDX = 13,
  parameter int TRIG_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sys_reset_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  logic              in_range;
  logic              is_rstctl;
  logic [WORD_W-1:0] rd_word;
  logic              wr_ok;
  logic              rd_ok;
  logic              unused_low;

  assign word_idx   = bus_addr[ADDR_W-1:2];
  assign unused_low = ^bus_addr[1:0];
  assign wr_ok      = bus_valid && bus_write && in_range;
  assign rd_ok      = bus_valid && !bus_write;

  sysctl_addr_dec #(
    .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS), .RSTCTL_IDX(RSTCTL_IDX)
  ) u_dec (
    .word_idx(word_idx), .in_range(in_range), .is_rstctl(is_rstctl)
  );

  sysctl_word_file #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) u_file (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .idx(word_idx),
    .wr_data(bus_wdata), .rd_word(rd_word)
  );

  sysctl_rst_pulse #(.TRIG_BIT(TRIG_BIT)) u_pulse (
    .clk(clk), .rst(rst), .ctl_write(wr_ok && is_rstctl),
    .ctl_data(bus_wdata), .req(sys_reset_req)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_ok)
      bus_rdata <= in_range ? rd_word : '0;
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int ADDR_W     = 12,
  parameter int NUM_WORDS  = 65,
  parameter int RSTCTL_IDX = 13,
  parameter int TRIG_BIT   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              sys_reset_req
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] c_idx;
  logic             unused_chk;
  assign c_idx      = bus_addr[ADDR_W-1:2];
  assign unused_chk = ^bus_addr[1:0];

  // R4
  rdata_cleared_in_reset_chk: assert property (@(posedge clk)
    rst |=> bus_rdata == 32'h0);

  // R4
  rdata_holds_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

  // R6
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && c_idx >= IDX_W'(NUM_WORDS)) |=> bus_rdata == 32'h0);

  // R5
  read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && c_idx < IDX_W'(NUM_WORDS) &&
     $past(bus_valid && bus_write) && $past(c_idx) == c_idx)
    |=> bus_rdata == $past(bus_wdata, 2));

  // R8
  pulse_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(bus_valid && bus_write &&
                            c_idx == IDX_W'(RSTCTL_IDX) && bus_wdata[TRIG_BIT]));

  // R8
  pulse_follows_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && c_idx == IDX_W'(RSTCTL_IDX) && bus_wdata[TRIG_BIT])
    |=> sys_reset_req);

  // R9
  no_pulse_without_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write && bus_wdata[TRIG_BIT]) |=> !sys_reset_req);
endmodule

bind sysctl_regs sysctl_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RSTCTL_IDX(RSTCTL_IDX), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sys_reset_req(sys_reset_req)
);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  sysctl_regs uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_reset_req(sys_reset_req)
  );

  always @(negedge clk) if (sys_reset_req) pulses++;

  function automatic logic [31:0] expected_init(input int w);
    case (w)
      0: return 32'h3637544D;  1: return 32'h20203832;
      2: return 32'h01010000;  3: return 32'h00010102;
      4: return 32'h00144144;  5: return 32'h02605500;
      11: return 32'h00201000; 12: return 32'hF69F7F00;
      13: return 32'h04000400; 14: return 32'hC0030000;
      15: return 32'h001F001F; 24: return 32'h54050404;
      25: return 32'h05550555;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R4 rdata in reset", bus_rdata, 32'h0);
    for (int w = 0; w < 65; w++) begin
      rd(12'(w * 4), d);
      if (expected_init(w) != 0 && w < 4)       check("R1 identity word", d, expected_init(w));
      else if (expected_init(w) != 0)           check("R2 config word", d, expected_init(w));
      else                                      check("R3 zero word", d, 32'h0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(12'h000, 32'hDEADBEEF); rd(12'h000, d); check("R5 identity write", d, 32'hDEADBEEF);
    wr(12'h100, 32'hA5A55A5A); rd(12'h100, d); check("R5 last word", d, 32'hA5A55A5A);
    wr(12'h064, 32'h00000000); rd(12'h064, d); check("R5 pinmux cleared", d, 32'h0);
    wr(12'h040, 32'h12345678); rd(12'h040, d); check("R5 spare word", d, 32'h12345678);
    rd(12'h004, d); check("R5 neighbour untouched", d, 32'h20203832);
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    rd(12'h040, d);
    check("R4 latency", d, 32'h12345678);
    idle(3);
    check("R4 hold idle", bus_rdata, 32'h12345678);
    wr(12'h040, 32'h0BADF00D);
    idle(1);
    check("R4 hold over write", bus_rdata, 32'h12345678);
  endtask

  task automatic t_out_of_range();
    logic [31:0] d;
    int p0;
    rd(12'h104, d); check("R6 first oob read", d, 32'h0);
    rd(12'hFFC, d); check("R6 top oob read", d, 32'h0);
    wr(12'h034, 32'h11110000);
    p0 = pulses;
    wr(12'h104, 32'hFFFFFFFF);
    wr(12'h134, 32'hFFFFFFFF);
    wr(12'h204, 32'hFFFFFFFF);
    idle(2);
    check("R7 no pulse from oob", 32'(pulses - p0), 32'd0);
    rd(12'h034, d); check("R7 rstctl unchanged", d, 32'h11110000);
    rd(12'h004, d); check("R7 word1 unchanged", d, 32'h20203832);
    rd(12'h100, d); check("R7 last word unchanged", d, 32'hA5A55A5A);
  endtask

  task automatic t_rst_pulse();
    logic [31:0] d;
    int p0;
    p0 = pulses;
    wr(12'h034, 32'h80000001);
    check("R8 pulse high", 32'(sys_reset_req), 32'd1);
    rd(12'h034, d);
    check("R8 pulse one cycle", 32'(sys_reset_req), 32'd0);
    check("R8 value stored", d, 32'h80000001);
    idle(5);
    check("R9 stored bit no retrigger", 32'(pulses - p0), 32'd1);
  endtask

  task automatic t_no_pulse();
    logic [31:0] d;
    int p0;
    p0 = pulses;
    wr(12'h034, 32'hFFFFFFFE);
    wr(12'h030, 32'h00000001);
    wr(12'h038, 32'h00000001);
    rd(12'h034, d);
    idle(2);
    check("R9 no pulse", 32'(pulses - p0), 32'd0);
    check("R9 rstctl stored", d, 32'hFFFFFFFE);
  endtask

  task automatic t_low_bits();
    logic [31:0] d;
    int p0;
    p0 = pulses;
    wr(12'h037, 32'h00000003);
    check("R10 pulse via unaligned", 32'(sys_reset_req), 32'd1);
    rd(12'h035, d);
    check("R10 unaligned read", d, 32'h00000003);
    wr(12'h042, 32'hCAFEBABE);
    rd(12'h040, d);
    check("R10 unaligned write", d, 32'hCAFEBABE);
    idle(1);
    check("R10 pulse count", 32'(pulses - p0), 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R4 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    t_reset_state();
    t_readback();
    t_read_hold();
    t_out_of_range();
    t_rst_pulse();
    t_no_pulse();
    t_low_bits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule